// File: doc/BRIEF.md
# Pre/Post Trigger Sample Capture Buffer

This block records a short stream of samples around an event. Every accepted sample is written into a small circular memory at a wrapping write address. Until an event arrives, older samples are overwritten. An asynchronous trigger input is first brought into the clock domain and edge-detected. The first trigger edge after arming starts a post-trigger count. The write address in use at that moment is saved. After a fixed number of further writes, writing stops and the memory holds a frozen window: the samples just before the event, followed by the samples from the event onward.

Software or a host engine then reads the frozen window through a simple read port, starting at the recorded trigger address. A rearm strobe restarts capture for the next event.

With the default sizes, the memory has 8 entries and the post-trigger count is 4. The frozen window therefore holds 4 samples before the trigger and 4 from the trigger onward.

Top module: `trigcap_top`

## Requirements
- R1: Each cycle in which `sampleValid` is high and `done` is low writes `sampleData` at the current write address. The write address then advances by one, wrapping from DEPTH-1 to 0. After reset or rearm, the write address is 0.
- R2: `trigIn` is passed through a two-flop synchronizer and a rising-edge detector. A rise between clock edges k and k+1 is acted on at edge k+3. The first post-trigger sample is the first one written at or after that edge.
- R3: `trigLoc` holds the write address at the moment the trigger is accepted. This is the address of the first post-trigger sample.
- R4: After the trigger is accepted, exactly POST_SAMPLES (default 4) samples are written, counting the sample on the accept cycle. `done` rises on the edge of the last of these writes. The frozen memory then holds the DEPTH-POST_SAMPLES samples that precede the trigger sample, followed by the POST_SAMPLES samples from it onward, going up from `trigLoc` modulo DEPTH.
- R5: While `done` is high, samples are not written, so the memory contents do not change.
- R6: Only the first trigger edge after reset or rearm is accepted. Later edges before the next rearm leave `trigLoc` and the post-trigger count unchanged.
- R7: Reset and `rearm` each clear `done` and `trigLoc` to 0, set the write address to 0, and reload the post-trigger count.
- R8: `rdData` shows the word stored at `rdAddr` combinationally while `done` is high, and reads as 0 while `done` is low.
- R9: `done` stays low from rearm until the final post-trigger write, and stays high until the next rearm or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm | input | 1 | Restart capture: clears the frozen window state |
| sampleData | input | DATA_W | Incoming sample word |
| sampleValid | input | 1 | Sample strobe for the current cycle |
| trigIn | input | 1 | Asynchronous trigger level |
| rdAddr | input | ADDR_W | Read address into the frozen window |
| rdData | output | DATA_W | Stored word at `rdAddr` (0 while not done) |
| trigLoc | output | ADDR_W | Write address of the first post-trigger sample |
| done | output | 1 | Window frozen |

## Verification
The embedded properties check, on every cycle, the step-by-one wrap of the write address. They also check that `done` is sticky and suppresses writes, that rearm clears the capture state, that `trigLoc` moves only on an accepted trigger, and that the edge detector never fires two cycles in a row.

Only the bench's scenarios can show the following: the three-edge trigger latency across sub-cycle trigger offsets, the exact split of pre- and post-trigger samples in the frozen memory, and the rejection of a second trigger pulse. It sweeps trigger offsets, sample-valid densities and trigger positions against an arithmetic model of the window.

// File: rtl/trigcap_pkg.sv
package trigcap_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic wrEn;      // store current sample and advance address
    logic clearAll;  // rearm: address and trigger location back to zero
    logic latchLoc;  // capture address as trigger location
  } ctrlStrobes_t;
endpackage

// File: rtl/trigcap_sync.sv
module trigcap_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic asyncIn,
  output logic riseSeen
);
  logic [SYNC_STAGES-1:0] chain;
  logic lastLevel;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= asyncIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[g] <= 1'b0;
          else     chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lastLevel <= 1'b0;
    else     lastLevel <= chain[SYNC_STAGES-1];
  end

  assign riseSeen = chain[SYNC_STAGES-1] & ~lastLevel;

  // R2: a single rise yields a one-cycle pulse
  p_edge_single_r2: assert property (@(posedge clk) disable iff (rst)
    riseSeen |=> !riseSeen);
endmodule

// File: rtl/trigcap_ctrl.sv
module trigcap_ctrl
  import trigcap_pkg::*;
#(
  parameter int POST_SAMPLES = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rearm,
  input  logic         sampleValid,
  input  logic         trigEdge,
  output ctrlStrobes_t strobes,
  output logic         done
);
  localparam int CNT_W = (POST_SAMPLES > 1) ? $clog2(POST_SAMPLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(POST_SAMPLES - 1);

  logic [CNT_W-1:0] postCnt;
  logic trigSeen;
  logic doneQ;
  logic accept;
  logic counting;
  logic wrNow;

  assign accept   = trigEdge & ~trigSeen & ~doneQ & ~rearm;
  assign counting = trigSeen | accept;
  assign wrNow    = sampleValid & ~doneQ & ~rearm;

  always_ff @(posedge clk) begin
    if (rst || rearm) begin
      postCnt  <= CNT_LOAD;
      trigSeen <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      if (accept) trigSeen <= 1'b1;
      if (wrNow && counting) begin
        if (postCnt == '0) doneQ <= 1'b1;
        else               postCnt <= postCnt - 1'b1;
      end
    end
  end

  always_comb begin
    strobes.wrEn     = wrNow;
    strobes.clearAll = rearm;
    strobes.latchLoc = accept;
  end

  assign done = doneQ;

  // R5: frozen window stays frozen until rearm
  p_done_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> done);
  p_no_write_done_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !strobes.wrEn);
  // R7: rearm clears the capture state
  p_rearm_clears_r7: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (!done && !trigSeen && postCnt == CNT_LOAD));
  // R4: a window only freezes after a trigger was accepted
  p_done_after_trig_r4: assert property (@(posedge clk) disable iff (rst)
    done |-> trigSeen);
  // R6: no second accept once triggered
  p_single_accept_r6: assert property (@(posedge clk) disable iff (rst)
    trigSeen |-> !strobes.latchLoc);
endmodule

// File: rtl/trigcap_datapath.sv
module trigcap_datapath
  import trigcap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic              done,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] trigLoc
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] locQ;

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAll) begin
      wrAddr <= '0;
      locQ   <= '0;
    end else begin
      if (strobes.latchLoc) locQ <= wrAddr;
      if (strobes.wrEn)     wrAddr <= wrAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.wrEn) store[wrAddr] <= sampleData;
  end

  assign rdData  = done ? store[rdAddr] : '0;
  assign trigLoc = locQ;

  // R1: each write advances the address by one, wrapping
  p_addr_step_r1: assert property (@(posedge clk) disable iff (rst)
    (strobes.wrEn && !strobes.clearAll) |=> (wrAddr == $past(wrAddr) + 1'b1));
  p_addr_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (!strobes.wrEn && !strobes.clearAll) |=> $stable(wrAddr));
  // R6: trigger location moves only on an accepted trigger or rearm
  p_loc_stable_r6: assert property (@(posedge clk) disable iff (rst)
    (!strobes.latchLoc && !strobes.clearAll) |=> $stable(trigLoc));
endmodule

// File: rtl/trigcap_top.sv
module trigcap_top
  import trigcap_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ADDR_W       = 3,
  parameter int POST_SAMPLES = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rearm,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              sampleValid,
  input  logic              trigIn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] trigLoc,
  output logic              done
);
  ctrlStrobes_t strobes;
  logic trigEdge;

  trigcap_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .asyncIn(trigIn), .riseSeen(trigEdge)
  );

  trigcap_ctrl #(.POST_SAMPLES(POST_SAMPLES)) u_ctrl (
    .clk(clk), .rst(rst), .rearm(rearm), .sampleValid(sampleValid),
    .trigEdge(trigEdge), .strobes(strobes), .done(done)
  );

  trigcap_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes), .done(done),
    .sampleData(sampleData), .rdAddr(rdAddr), .rdData(rdData),
    .trigLoc(trigLoc)
  );
endmodule

// File: tb/trigcap_top_tb.sv
module trigcap_top_tb;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 8;
  localparam int POST   = 4;

  logic clk = 1'b0;
  logic rst, rearm, sampleValid, trigIn;
  logic [DATA_W-1:0] sampleData;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic [ADDR_W-1:0] trigLoc;
  logic done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  trigcap_top u_dut (
    .clk(clk), .rst(rst), .rearm(rearm), .sampleData(sampleData),
    .sampleValid(sampleValid), .trigIn(trigIn), .rdAddr(rdAddr),
    .rdData(rdData), .trigLoc(trigLoc), .done(done)
  );

  // model state
  logic [DATA_W-1:0] mMem [DEPTH];
  int mAddr, mCnt, mLoc;
  bit mSeen, mDone;
  logic [DATA_W-1:0] seq;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runCase(input int pat, input int off, input int k, input bit second);
    @(posedge clk); #2;
    rearm = 1'b1; sampleValid = 1'b0; trigIn = 1'b0;
    @(posedge clk); #2;
    rearm = 1'b0;
    mAddr = 0; mCnt = POST - 1; mLoc = 0; mSeen = 0; mDone = 0;
    for (int j = 0; j < 40; j++) begin
      if (j > 0) begin @(posedge clk); #2; end
      // R9: done tracks the model after each edge
      chk(done === mDone, "R9 done", done, mDone);
      if (j == 0) begin
        rdAddr = '0; #1;
        chk(rdData === '0, "R8 read zero while capturing", rdData, 0);
        chk(trigLoc === '0, "R7 trigLoc after rearm", trigLoc, 0);
      end
      if (j == k + 1) trigIn = 1'b0;
      if (second && j == k + 5) trigIn = 1'b0;
      case (pat)
        0: sampleValid = 1'b1;
        1: sampleValid = (j % 2 == 0);
        default: sampleValid = (j % 3 == 0);
      endcase
      sampleData = seq;
      // model: trigger rise in iteration k is acted on at iteration k+2
      if (j == k + 2 && !mSeen && !mDone) begin
        mSeen = 1; mLoc = mAddr;
      end
      if (sampleValid && !mDone) begin
        mMem[mAddr] = seq;
        mAddr = (mAddr + 1) % DEPTH;
        if (mSeen) begin
          if (mCnt == 0) mDone = 1;
          else mCnt--;
        end
      end
      if (sampleValid) seq++;
      if (j == k || (second && j == k + 4)) begin
        #(off); trigIn = 1'b1;
      end
    end
    @(posedge clk); #2;
    sampleValid = 1'b0; trigIn = 1'b0;
    chk(done === 1'b1, "R4 window frozen", done, 1);
    chk(trigLoc === mLoc[ADDR_W-1:0], "R2/R3 trigger location", trigLoc, mLoc);
    for (int a = 0; a < DEPTH; a++) begin
      rdAddr = a[ADDR_W-1:0]; #1;
      chk(rdData === mMem[a], "R1/R4/R5/R6 window word", rdData, mMem[a]);
    end
    // window ordering relative to trigLoc (pre samples then post samples)
    for (int i = -(DEPTH - POST); i < POST - 1; i++) begin
      int aa;
      int bb;
      aa = (mLoc + i + DEPTH) % DEPTH;
      bb = (mLoc + i + 1 + DEPTH) % DEPTH;
      rdAddr = aa[ADDR_W-1:0]; #1;
      begin
        logic [DATA_W-1:0] w0;
        w0 = rdData;
        rdAddr = bb[ADDR_W-1:0]; #1;
        chk(rdData > w0 || (w0 > 8'd200 && rdData < 8'd60),
            "R4 window order", rdData, w0);
      end
    end
  endtask

  initial begin
    rst = 1'b1; rearm = 1'b0; sampleValid = 1'b0; trigIn = 1'b0;
    sampleData = '0; rdAddr = '0; seq = 8'd1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    #1;
    chk(done === 1'b0, "R7 done after reset", done, 0);
    chk(trigLoc === '0, "R7 trigLoc after reset", trigLoc, 0);
    chk(rdData === '0, "R8 read zero after reset", rdData, 0);
    for (int pat = 0; pat < 3; pat++)
      for (int oi = 0; oi < 5; oi++)
        for (int ki = 0; ki < 2; ki++)
          runCase(pat, 1 + oi * 4, (ki == 0) ? 8 : 11, (oi % 2) == 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule